// File: doc/BRIEF.md
# Coded Radar Transmit Frame Sequencer

This block produces the digital drive samples for a coded radar transmitter. Each repetition period it emits one frame with three parts in a fixed order. A short bipolar monocycle pulse comes first and acts as a coarse time marker. A 31-chip maximal-length sequence follows at a fixed delay and gives the receiver fine timing. A 2047-chip maximal-length sequence comes last, at a second fixed delay, and is used for deep-target pulse compression. Both sequences are binary phase-modulated onto a sine carrier produced by a phase accumulator and a quarter-wave lookup. Each part has its own drive level.

A controller state machine walks through the named states OFF, MONO, GAP_A, SHORT, GAP_B, LONG and TAIL, using a frame offset counter. The transitions are: OFF→MONO when enabled; MONO→GAP_A after the last monocycle sample; GAP_A→SHORT at the short-sequence offset; SHORT→GAP_B after the last short chip; GAP_B→LONG at the long-sequence offset; LONG→TAIL after the last long chip; TAIL→MONO at the end of the frame if enable is high, otherwise TAIL→OFF. Enable is examined only in OFF and on the last cycle of a frame, so a frame that has started always runs to completion.

All outputs are registered together. The offsets below count output cycles from the frame-start strobe, which is offset 0.

Top module: `coded_frame_sequencer`

## Requirements
- R1: While reset is asserted, and after reset until enable is first seen high, `seg_o` is 0, `sample_o` is 0 and `frame_start_o` is 0.
- R2: While enable stays high, `frame_start_o` is high for exactly one cycle per frame and recurs every 30000 cycles.
- R3: On offsets 0..11, `seg_o` is 1 and `sample_o` equals (M[k]*30000)>>>15 with floor rounding. The table M is 0, 9830, 26214, 32767, 19661, 0, -19661, -32767, -26214, -9830, 0, 0.
- R4: On offsets 525..896 (31 chips of 12 cycles each), `seg_o` is 2.
- R5: On offsets 2025..26588 (2047 chips of 12 cycles each), `seg_o` is 3.
- R6: On every other offset of a frame, `seg_o` is 0 and `sample_o` is 0.
- R7: At sample k of a sequence segment, counted from 0 at the segment's first sample, `sample_o` is within 6% of G plus 4 of G·sin(2π·0.08·k)·s. G is the segment gain and s is -1 when the current chip is 1, otherwise +1. The carrier phase restarts at each segment.
- R8: Short chips come from a 5-bit register seeded to 11111. The chip is bit 0. Every 12 samples the register shifts right, with the new bit 4 equal to bit0 XOR bit2.
- R9: Long chips come from an 11-bit register seeded to all ones. The chip is bit 0. Every 12 samples the register shifts right, with the new bit 10 equal to bit0 XOR bit2.
- R10: The gains are 30000 for the monocycle, 8000 for the short sequence and 16000 for the long sequence. The peak |sample_o| in each sequence segment lies between 90% and 100% of its gain.
- R11: When enable is dropped mid-frame, the frame completes unchanged and then `seg_o` and `sample_o` stay 0 with no strobe. When enable is raised from idle, the strobe appears on the second rising edge.
- R12: Both sequence registers are reseeded every frame, so consecutive frames are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run frames; checked at frame boundaries |
| sample_o | output | 16 | Signed drive sample |
| seg_o | output | 2 | Segment: 0 idle, 1 monocycle, 2 short, 3 long |
| frame_start_o | output | 1 | One-cycle strobe at the first monocycle sample |

## Verification
Two events can coincide. On the last sample of a sequence segment, the chip counter reaches its limit in the same cycle as the state leaves SHORT or LONG; that step must not spill into the gap or corrupt the next frame's seed. On the last cycle of a frame, the wrap of the offset counter falls together with the sampling of enable. The bench drops enable near the end of the second frame and compares every sample of that frame against a model reseeded from scratch, then confirms that no strobe follows. It then raises enable from idle and checks the two-edge start latency and a full third frame.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_MONO,
        ST_GAP_A,
        ST_SHORT,
        ST_GAP_B,
        ST_LONG,
        ST_TAIL
    } frame_state_e;

    typedef enum logic [1:0] {
        SEG_IDLE  = 2'd0,
        SEG_MONO  = 2'd1,
        SEG_SHORT = 2'd2,
        SEG_LONG  = 2'd3
    } seg_e;

    localparam int WAVE_W   = 16;
    localparam int FRAC_W   = 15;
    localparam int MONO_IW  = 4;
    localparam int QLUT_IW  = 4;

    // Bipolar doublet, Q15, twelve samples
    function automatic logic signed [WAVE_W-1:0] mono_rom(input logic [MONO_IW-1:0] idx);
        logic signed [WAVE_W-1:0] v;
        unique case (idx)
            4'd1:    v = 16'sd9830;
            4'd2:    v = 16'sd26214;
            4'd3:    v = 16'sd32767;
            4'd4:    v = 16'sd19661;
            4'd6:    v = -16'sd19661;
            4'd7:    v = -16'sd32767;
            4'd8:    v = -16'sd26214;
            4'd9:    v = -16'sd9830;
            default: v = 16'sd0;
        endcase
        return v;
    endfunction

    // First quadrant of a sine, bin centres, Q15
    function automatic logic [WAVE_W-1:0] quarter_sine(input logic [QLUT_IW-1:0] idx);
        logic [WAVE_W-1:0] v;
        unique case (idx)
            4'd0:    v = 16'd1608;
            4'd1:    v = 16'd4808;
            4'd2:    v = 16'd7962;
            4'd3:    v = 16'd11039;
            4'd4:    v = 16'd14010;
            4'd5:    v = 16'd16846;
            4'd6:    v = 16'd19520;
            4'd7:    v = 16'd22005;
            4'd8:    v = 16'd24279;
            4'd9:    v = 16'd26319;
            4'd10:   v = 16'd28106;
            4'd11:   v = 16'd29621;
            4'd12:   v = 16'd30852;
            4'd13:   v = 16'd31785;
            4'd14:   v = 16'd32413;
            default: v = 16'd32728;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfs_lfsr.sv
module cfs_lfsr #(
    parameter int          WIDTH = 5,
    parameter int          TAP   = 2,
    parameter logic [WIDTH-1:0] SEED = '1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic step_i,
    output logic chip_o
);

    logic [WIDTH-1:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= SEED;
        end else if (load_i) begin
            q <= SEED;
        end else if (step_i) begin
            q <= {q[0] ^ q[TAP], q[WIDTH-1:1]};
        end
    end

    assign chip_o = q[0];

    // R8 / R9: a maximal-length register never falls into the all-zero lockup
    a_r8_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q != '0);

    // R12: a load always restores the seed on the next cycle
    a_r12_reseed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> q == SEED);

endmodule

// File: rtl/cfs_carrier.sv
module cfs_carrier
    import cfs_pkg::*;
#(
    parameter int                 PHASE_W = 32,
    parameter logic [PHASE_W-1:0] INC     = 32'd343597384
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     run_i,
    output logic signed [WAVE_W-1:0] sine_o
);

    localparam int IDX_LO = PHASE_W - 2 - QLUT_IW;

    logic [PHASE_W-1:0] acc;
    logic [1:0]         quad;
    logic [QLUT_IW-1:0] idx;
    logic [QLUT_IW-1:0] idx_m;
    logic [WAVE_W-1:0]  mag;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc <= '0;
        end else if (run_i) begin
            acc <= acc + INC;
        end else begin
            acc <= '0;
        end
    end

    always_comb begin
        quad   = acc[PHASE_W-1 -: 2];
        idx    = acc[IDX_LO +: QLUT_IW];
        idx_m  = quad[0] ? ~idx : idx;
        mag    = quarter_sine(idx_m);
        sine_o = quad[1] ? -$signed(mag) : $signed(mag);
    end

    // R7: the phase starts from zero on the first sample of each segment
    a_r7_phase_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> acc == '0);

endmodule

// File: rtl/cfs_frame_ctrl.sv
module cfs_frame_ctrl
    import cfs_pkg::*;
#(
    parameter int FRAME_LEN = 30000,
    parameter int MONO_LEN  = 12,
    parameter int SHORT_OFS = 525,
    parameter int SHORT_LEN = 372,
    parameter int LONG_OFS  = 2025,
    parameter int LONG_LEN  = 24564,
    parameter int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    output frame_state_e     state_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] MONO_END    = CNT_W'(MONO_LEN - 1);
    localparam logic [CNT_W-1:0] SHORT_PRE   = CNT_W'(SHORT_OFS - 1);
    localparam logic [CNT_W-1:0] SHORT_END   = CNT_W'(SHORT_OFS + SHORT_LEN - 1);
    localparam logic [CNT_W-1:0] LONG_PRE    = CNT_W'(LONG_OFS - 1);
    localparam logic [CNT_W-1:0] LONG_END    = CNT_W'(LONG_OFS + LONG_LEN - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST  = CNT_W'(FRAME_LEN - 1);

    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en_i)                 state_d = ST_MONO;
            ST_MONO:  if (cnt_q == MONO_END)    state_d = ST_GAP_A;
            ST_GAP_A: if (cnt_q == SHORT_PRE)   state_d = ST_SHORT;
            ST_SHORT: if (cnt_q == SHORT_END)   state_d = ST_GAP_B;
            ST_GAP_B: if (cnt_q == LONG_PRE)    state_d = ST_LONG;
            ST_LONG:  if (cnt_q == LONG_END)    state_d = ST_TAIL;
            ST_TAIL:  if (cnt_q == FRAME_LAST)  state_d = en_i ? ST_MONO : ST_OFF;
            default:                            state_d = ST_OFF;
        endcase

        if (state_q == ST_OFF || cnt_q == FRAME_LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;

    // R2: the offset counter never passes the frame length
    a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= FRAME_LAST);

    // R11: while idle the offset stays parked at zero
    a_r11_off_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_OFF |-> cnt_q == '0);

    // R2: every running frame starts at offset zero in the monocycle state
    a_r2_wrap_to_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_OFF && cnt_q == FRAME_LAST && en_i) |=> (state_q == ST_MONO && cnt_q == '0));

    // R11: enable is ignored inside a frame
    a_r11_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_OFF && state_q != ST_TAIL) |=> state_q != ST_OFF);

endmodule

// File: rtl/coded_frame_sequencer.sv
module coded_frame_sequencer
    import cfs_pkg::*;
#(
    parameter int          FRAME_LEN   = 30000,
    parameter int          MONO_LEN    = 12,
    parameter int          SHORT_DELAY = 525,
    parameter int          LONG_DELAY  = 1500,
    parameter int          CHIP_CLKS   = 12,
    parameter int          SHORT_BITS  = 5,
    parameter int          LONG_BITS   = 11,
    parameter int          LFSR_TAP    = 2,
    parameter int          PHASE_W     = 32,
    parameter logic [31:0] PHASE_INC   = 32'd343597384,
    parameter int          GAIN_MONO   = 30000,
    parameter int          GAIN_SHORT  = 8000,
    parameter int          GAIN_LONG   = 16000,
    parameter int          SAMPLE_W    = 16
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       en_i,
    output logic signed [SAMPLE_W-1:0] sample_o,
    output logic [1:0]                 seg_o,
    output logic                       frame_start_o
);

    localparam int SHORT_CHIPS = (1 << SHORT_BITS) - 1;
    localparam int LONG_CHIPS  = (1 << LONG_BITS) - 1;
    localparam int SHORT_LEN   = SHORT_CHIPS * CHIP_CLKS;
    localparam int LONG_LEN    = LONG_CHIPS * CHIP_CLKS;
    localparam int SHORT_OFS   = SHORT_DELAY;
    localparam int LONG_OFS    = SHORT_DELAY + LONG_DELAY;
    localparam int CNT_W       = $clog2(FRAME_LEN);
    localparam int CHIP_W      = $clog2(CHIP_CLKS);
    localparam int GAIN_W      = WAVE_W + 1;
    localparam int PROD_W      = WAVE_W + GAIN_W;

    localparam logic [CHIP_W-1:0]        CHIP_LAST = CHIP_W'(CHIP_CLKS - 1);
    localparam logic signed [GAIN_W-1:0] G_MONO    = GAIN_W'(GAIN_MONO);
    localparam logic signed [GAIN_W-1:0] G_SHORT   = GAIN_W'(GAIN_SHORT);
    localparam logic signed [GAIN_W-1:0] G_LONG    = GAIN_W'(GAIN_LONG);

    frame_state_e             state;
    logic [CNT_W-1:0]         cnt;
    logic [CHIP_W-1:0]        chip_cnt;
    logic                     seq_run;
    logic                     chip_end;
    logic                     seed_load;
    logic                     chip_short;
    logic                     chip_long;
    logic signed [WAVE_W-1:0] sine;

    logic signed [WAVE_W-1:0]   base_d;
    logic signed [GAIN_W-1:0]   gain_d;
    logic signed [PROD_W-1:0]   prod_d;
    logic signed [SAMPLE_W-1:0] sample_d;
    seg_e                       seg_d;

    // Frame timing controller
    cfs_frame_ctrl #(
        .FRAME_LEN (FRAME_LEN),
        .MONO_LEN  (MONO_LEN),
        .SHORT_OFS (SHORT_OFS),
        .SHORT_LEN (SHORT_LEN),
        .LONG_OFS  (LONG_OFS),
        .LONG_LEN  (LONG_LEN),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .state_o (state),
        .cnt_o   (cnt)
    );

    assign seq_run   = (state == ST_SHORT) || (state == ST_LONG);
    assign chip_end  = seq_run && (chip_cnt == CHIP_LAST);
    assign seed_load = (state == ST_OFF) || (state == ST_MONO);

    // Chip timer: restarts at each sequence segment
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chip_cnt <= '0;
        end else if (!seq_run || chip_end) begin
            chip_cnt <= '0;
        end else begin
            chip_cnt <= chip_cnt + 1'b1;
        end
    end

    // One code generator per sequence segment
    cfs_lfsr #(
        .WIDTH (SHORT_BITS),
        .TAP   (LFSR_TAP),
        .SEED  ('1)
    ) u_code_short (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (seed_load),
        .step_i (chip_end && (state == ST_SHORT)),
        .chip_o (chip_short)
    );

    cfs_lfsr #(
        .WIDTH (LONG_BITS),
        .TAP   (LFSR_TAP),
        .SEED  ('1)
    ) u_code_long (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (seed_load),
        .step_i (chip_end && (state == ST_LONG)),
        .chip_o (chip_long)
    );

    cfs_carrier #(
        .PHASE_W (PHASE_W),
        .INC     (PHASE_W'(PHASE_INC))
    ) u_carrier (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (seq_run),
        .sine_o (sine)
    );

    // Segment selection, modulation and gain
    always_comb begin
        base_d = '0;
        gain_d = '0;
        seg_d  = SEG_IDLE;
        unique case (state)
            ST_MONO: begin
                seg_d  = SEG_MONO;
                base_d = mono_rom(cnt[MONO_IW-1:0]);
                gain_d = G_MONO;
            end
            ST_SHORT: begin
                seg_d  = SEG_SHORT;
                base_d = chip_short ? -sine : sine;
                gain_d = G_SHORT;
            end
            ST_LONG: begin
                seg_d  = SEG_LONG;
                base_d = chip_long ? -sine : sine;
                gain_d = G_LONG;
            end
            default: begin
                seg_d  = SEG_IDLE;
                base_d = '0;
                gain_d = '0;
            end
        endcase
        prod_d   = base_d * gain_d;
        sample_d = SAMPLE_W'(prod_d >>> FRAC_W);
    end

    // Output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sample_o      <= '0;
            seg_o         <= SEG_IDLE;
            frame_start_o <= 1'b0;
        end else begin
            sample_o      <= sample_d;
            seg_o         <= seg_d;
            frame_start_o <= (state == ST_MONO) && (cnt == '0);
        end
    end

    // R2 / R3: the strobe marks a monocycle sample and is one cycle wide
    a_r2_strobe_in_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_o |-> seg_o == SEG_MONO);

    a_r3_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_o |=> (!frame_start_o && seg_o == SEG_MONO));

    // R6: an idle segment is silent
    a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seg_o == SEG_IDLE |-> sample_o == '0);

    // R10: sequence drive never exceeds its gain
    a_r10_short_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seg_o == SEG_SHORT |-> (sample_o <= SAMPLE_W'(GAIN_SHORT) && sample_o >= -SAMPLE_W'(GAIN_SHORT)));

    a_r10_long_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seg_o == SEG_LONG |-> (sample_o <= SAMPLE_W'(GAIN_LONG) && sample_o >= -SAMPLE_W'(GAIN_LONG)));

    // R4 / R5: sequence segments are entered only from an idle gap
    a_r4_short_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seg_o == SEG_SHORT && $past(seg_o) != SEG_SHORT) |-> $past(seg_o) == SEG_IDLE);

    a_r5_long_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seg_o == SEG_LONG && $past(seg_o) != SEG_LONG) |-> $past(seg_o) == SEG_IDLE);

endmodule

// File: tb/tb_coded_frame_sequencer.sv
module tb_coded_frame_sequencer;

    localparam int FRAME  = 30000;
    localparam int S_OFS  = 525;
    localparam int S_END  = 896;
    localparam int L_OFS  = 2025;
    localparam int L_END  = 26588;
    localparam int CHIP   = 12;
    localparam int G_MONO = 30000;
    localparam int G_SH   = 8000;
    localparam int G_LG   = 16000;
    localparam real TWO_PI = 6.283185307179586;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b0;
    logic signed [15:0] sample;
    logic [1:0]         seg;
    logic               fstart;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    coded_frame_sequencer dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .en_i          (en),
        .sample_o      (sample),
        .seg_o         (seg),
        .frame_start_o (fstart)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    function automatic int mono_ref(input int k);
        int m;
        case (k)
            1: m = 9830;   2: m = 26214;  3: m = 32767;  4: m = 19661;
            6: m = -19661; 7: m = -32767; 8: m = -26214; 9: m = -9830;
            default: m = 0;
        endcase
        return (m * G_MONO) >>> 15;
    endfunction

    // Checks a whole frame, positioned on its strobe; optionally drops enable
    task automatic run_frame(input int frame_no, input int drop_at, input bit next_strobe);
        logic [4:0]  rs = 5'h1f;
        logic [10:0] rl = 11'h7ff;
        int pk_s = 0;
        int pk_l = 0;
        for (int o = 0; o < FRAME; o++) begin
            int  act = sample;
            int  es;
            int  k;
            int  g;
            bit  cb;
            real ev;
            if (o == drop_at) en = 1'b0;
            chk(fstart == (o == 0), "R2", fstart, (o == 0));
            if (o < 12) begin
                chk(seg == 2'd1, "R3", seg, 1);
                chk(act == mono_ref(o), "R3", act, mono_ref(o));
            end else if ((o >= S_OFS && o <= S_END) || (o >= L_OFS && o <= L_END)) begin
                bit sh = (o <= S_END);
                es = sh ? 2 : 3;
                chk(seg == 2'(es), sh ? "R4" : "R5", seg, es);
                k = sh ? o - S_OFS : o - L_OFS;
                if (k > 0 && k % CHIP == 0) begin
                    if (sh) rs = {rs[0] ^ rs[2], rs[4:1]};
                    else    rl = {rl[0] ^ rl[2], rl[10:1]};
                end
                cb = sh ? rs[0] : rl[0];
                g  = sh ? G_SH : G_LG;
                ev = $itor(g) * $sin(TWO_PI * 0.08 * k);
                if (cb) ev = -ev;
                // R7 carrier phase restart, R8/R9 chip signs, R12 for later frames
                chk(($itor(act) - ev <= $itor(g) * 0.06 + 4.0) && (ev - $itor(act) <= $itor(g) * 0.06 + 4.0),
                    (k < CHIP) ? "R7" : (frame_no > 1) ? "R12" : sh ? "R8" : "R9", act, $rtoi(ev));
                if (sh) pk_s = (act < 0 ? -act : act) > pk_s ? (act < 0 ? -act : act) : pk_s;
                else    pk_l = (act < 0 ? -act : act) > pk_l ? (act < 0 ? -act : act) : pk_l;
            end else begin
                chk(seg == 2'd0, "R6", seg, 0);
                chk(act == 0, "R6", act, 0);
            end
            @(negedge clk);
        end
        chk(pk_s <= G_SH && pk_s >= (G_SH * 9) / 10, "R10", pk_s, G_SH);
        chk(pk_l <= G_LG && pk_l >= (G_LG * 9) / 10, "R10", pk_l, G_LG);
        chk(fstart == next_strobe, next_strobe ? "R2" : "R11", fstart, next_strobe);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(seg == 2'd0 && sample == 0 && fstart == 1'b0, "R1", {seg, fstart}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(seg == 2'd0 && sample == 0 && fstart == 1'b0, "R1", {seg, fstart}, 0);
        end
    endtask

    task automatic t_start();
        en = 1'b1;
        @(negedge clk);
        chk(fstart == 1'b0, "R11", fstart, 0);
        @(negedge clk);
        chk(fstart == 1'b1, "R11", fstart, 1);
    endtask

    task automatic t_idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            chk(seg == 2'd0 && sample == 0 && fstart == 1'b0, "R11", {seg, fstart}, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        t_reset();
        t_start();
        run_frame(1, -1, 1'b1);
        run_frame(2, 29990, 1'b0);
        t_idle(31000);
        t_start();
        run_frame(3, 10, 1'b0);
        t_idle(50);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule